// File: doc/BRIEF.md
# Configurable Set/Reset Storage Register

This block is a clocked storage element of `WIDTH` bits whose control behaviour is fixed by parameters. The bits share one clock, one clock enable, two force inputs (`force_pri` and `force_alt`) and a global initialization input. One parameter picks the value that `force_pri` drives into the register (all ones or all zeros). `force_alt` always drives the opposite value. A second parameter picks the power-up value, and it is independent of the force target.

A mode parameter chooses how the force inputs act. In the none mode the register has no set or reset. In the synchronous mode a force acts at the next rising clock edge. In the asynchronous mode it acts at once, with no clock. Two enable parameters switch the set function and the reset function on or off one at a time. Between them these parameters cover all seven set/reset combinations. When both functions are requested together, the reset (drive to zero) wins.

Each control input has its own inversion parameter, and the inversion is absorbed inside the block. The clock enable can be declared as not used, in which case the register loads on every edge. The global initialization input loads the initial value asynchronously and overrides everything else.

Top module: `cfg_srff`

## Requirements
- R1: While the global init input is active, `q` equals the initial value (`INIT_ONE` = 1 gives all ones, 0 gives all zeros) at once and without a clock edge. This value is independent of the force target, and it overrides every other input.
- R2: An active `force_pri` with `force_alt` inactive drives every bit of `q` to `PRI_HIGH` (1 gives all ones, 0 gives all zeros).
- R3: An active `force_alt` with `force_pri` inactive drives every bit of `q` to the complement of `PRI_HIGH`.
- R4: When the set request (the force input whose target is one) and the reset request are active together, `q` becomes all zeros.
- R5: In synchronous mode (`KIND` = SRK_SYNC), a force changes `q` only at the next rising clock edge, and it takes effect even while the clock enable is inactive.
- R6: In asynchronous mode (`KIND` = SRK_ASYNC), a force changes `q` immediately without a clock edge. `q` keeps the forced value across clock edges while the force stays active.
- R7: Each of `ce`, `force_pri`, `force_alt` and `ginit` is active high when its `INV_*` parameter is 0 and active low when it is 1.
- R8: With `CE_USED` = 1 and no force active, a rising edge loads `d` into `q` while the enable is active, and leaves `q` unchanged while it is inactive.
- R9: With `CE_USED` = 0, the `ce` input has no effect and every rising edge with no force active loads `d`.
- R10: A function switched off by `HAS_SET` = 0 or `HAS_RST` = 0 has no effect: its force input is ignored, and it no longer wins over the other function.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| ginit | input | 1 | Global initialization, loads the initial value asynchronously |
| ce | input | 1 | Clock enable |
| force_pri | input | 1 | Force to the parameter-chosen target |
| force_alt | input | 1 | Force to the opposite of that target |
| d | input | WIDTH | Data input |
| q | output | WIDTH | Stored value |

## Verification
The bench builds three instances with different parameter sets. It checks that the initial value stays apart from the force target, since a design that tied the two together would come up holding the force value. It asserts set and reset in the same cycle to confirm that zero wins, which a design with the priority reversed would fail by producing ones. It checks that a synchronous force acts while the enable is low and does not act before the edge, which catches a force gated by the enable or wired asynchronously. Inverted controls, a tied-off enable and a switched-off function are each exercised on their own instance, so that a lost inversion or a leaking disabled input shows up as a wrong value at `q`.

// File: rtl/srff_pkg.sv
package srff_pkg;
   typedef enum logic [1:0] {
      SRK_NONE  = 2'd0,
      SRK_SYNC  = 2'd1,
      SRK_ASYNC = 2'd2
   } srk_e;
endpackage

// File: rtl/srff_pol.sv
// Polarity absorption for one control input.
module srff_pol #(
   parameter bit INV = 1'b0
) (
   input  logic pin,
   output logic act
);
   generate
      if (INV) begin : g_inv
         assign act = ~pin;
      end else begin : g_pass
         assign act = pin;
      end
   endgenerate
endmodule

// File: rtl/srff_resolve.sv
// Maps the two force inputs onto set and reset requests, masked by the enabled functions.
module srff_resolve #(
   parameter bit PRI_HIGH = 1'b0,
   parameter bit SET_ON   = 1'b1,
   parameter bit RST_ON   = 1'b1
) (
   input  logic pri_act,
   input  logic alt_act,
   output logic set_req,
   output logic rst_req
);
   logic set_raw;
   logic rst_raw;

   generate
      if (PRI_HIGH) begin : g_pri_sets
         assign set_raw = pri_act;
         assign rst_raw = alt_act;
      end else begin : g_pri_clears
         assign set_raw = alt_act;
         assign rst_raw = pri_act;
      end
   endgenerate

   assign set_req = SET_ON ? set_raw : 1'b0;
   assign rst_req = RST_ON ? rst_raw : 1'b0;
endmodule

// File: rtl/srff_store.sv
// Storage bank; the mode picks the set/reset timing variant.
module srff_store
   import srff_pkg::*;
#(
   parameter int   WIDTH    = 4,
   parameter srk_e KIND     = SRK_SYNC,
   parameter bit   INIT_ONE = 1'b0
) (
   input  logic             clk,
   input  logic             init_act,
   input  logic             ce_act,
   input  logic             set_req,
   input  logic             rst_req,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam logic [WIDTH-1:0] INIT_VEC = {WIDTH{INIT_ONE}};
   localparam logic [WIDTH-1:0] ONES     = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ZEROS    = {WIDTH{1'b0}};

   generate
      if (KIND == SRK_ASYNC) begin : g_async
         always_ff @(posedge clk or posedge init_act or posedge rst_req or posedge set_req) begin
            if (init_act)     q <= INIT_VEC;
            else if (rst_req) q <= ZEROS;
            else if (set_req) q <= ONES;
            else if (ce_act)  q <= d;
         end
      end else if (KIND == SRK_SYNC) begin : g_sync
         always_ff @(posedge clk or posedge init_act) begin
            if (init_act)     q <= INIT_VEC;
            else if (rst_req) q <= ZEROS;
            else if (set_req) q <= ONES;
            else if (ce_act)  q <= d;
         end
      end else begin : g_plain
         always_ff @(posedge clk or posedge init_act) begin
            if (init_act)    q <= INIT_VEC;
            else if (ce_act) q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/cfg_srff.sv
module cfg_srff
   import srff_pkg::*;
#(
   parameter int   WIDTH    = 4,
   parameter srk_e KIND     = SRK_SYNC,
   parameter bit   HAS_SET  = 1'b1,
   parameter bit   HAS_RST  = 1'b1,
   parameter bit   PRI_HIGH = 1'b0,
   parameter bit   INIT_ONE = 1'b0,
   parameter bit   CE_USED  = 1'b1,
   parameter bit   INV_CE   = 1'b0,
   parameter bit   INV_PRI  = 1'b0,
   parameter bit   INV_ALT  = 1'b0,
   parameter bit   INV_INIT = 1'b0
) (
   input  logic             clk,
   input  logic             ginit,
   input  logic             ce,
   input  logic             force_pri,
   input  logic             force_alt,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam bit SET_ON = HAS_SET && (KIND != SRK_NONE);
   localparam bit RST_ON = HAS_RST && (KIND != SRK_NONE);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("cfg_srff: WIDTH must be at least 1");
      end
      if (KIND != SRK_NONE && KIND != SRK_SYNC && KIND != SRK_ASYNC) begin : g_bad_kind
         $error("cfg_srff: unknown KIND");
      end
   endgenerate

   logic init_act, ce_pin_act, pri_act, alt_act, ce_act;
   logic set_req, rst_req;

   srff_pol #(.INV(INV_INIT)) u_pol_init (.pin(ginit),     .act(init_act));
   srff_pol #(.INV(INV_CE))   u_pol_ce   (.pin(ce),        .act(ce_pin_act));
   srff_pol #(.INV(INV_PRI))  u_pol_pri  (.pin(force_pri), .act(pri_act));
   srff_pol #(.INV(INV_ALT))  u_pol_alt  (.pin(force_alt), .act(alt_act));

   generate
      if (CE_USED) begin : g_ce_live
         assign ce_act = ce_pin_act;
      end else begin : g_ce_tied
         assign ce_act = 1'b1;
      end
   endgenerate

   srff_resolve #(
      .PRI_HIGH(PRI_HIGH), .SET_ON(SET_ON), .RST_ON(RST_ON)
   ) u_resolve (
      .pri_act(pri_act), .alt_act(alt_act),
      .set_req(set_req), .rst_req(rst_req)
   );

   srff_store #(
      .WIDTH(WIDTH), .KIND(KIND), .INIT_ONE(INIT_ONE)
   ) u_store (
      .clk(clk), .init_act(init_act), .ce_act(ce_act),
      .set_req(set_req), .rst_req(rst_req), .d(d), .q(q)
   );
endmodule

// File: rtl/cfg_srff_chk.sv
module cfg_srff_chk
   import srff_pkg::*;
#(
   parameter int   WIDTH    = 4,
   parameter srk_e KIND     = SRK_SYNC,
   parameter bit   HAS_SET  = 1'b1,
   parameter bit   HAS_RST  = 1'b1,
   parameter bit   PRI_HIGH = 1'b0,
   parameter bit   INIT_ONE = 1'b0,
   parameter bit   CE_USED  = 1'b1,
   parameter bit   INV_CE   = 1'b0,
   parameter bit   INV_PRI  = 1'b0,
   parameter bit   INV_ALT  = 1'b0,
   parameter bit   INV_INIT = 1'b0
) (
   input logic             clk,
   input logic             ginit,
   input logic             ce,
   input logic             force_pri,
   input logic             force_alt,
   input logic [WIDTH-1:0] d,
   input logic [WIDTH-1:0] q
);
   localparam bit PRI_ON = (KIND != SRK_NONE) && (PRI_HIGH ? HAS_SET : HAS_RST);
   localparam bit ALT_ON = (KIND != SRK_NONE) && (PRI_HIGH ? HAS_RST : HAS_SET);
   localparam logic [WIDTH-1:0] PRI_VEC = {WIDTH{PRI_HIGH}};
   localparam logic [WIDTH-1:0] ALT_VEC = {WIDTH{~PRI_HIGH}};

   logic g_a, ce_a, p_a, a_a, p_eff, a_eff, quiet;
   assign g_a   = ginit ^ INV_INIT;
   assign ce_a  = CE_USED ? (ce ^ INV_CE) : 1'b1;
   assign p_a   = force_pri ^ INV_PRI;
   assign a_a   = force_alt ^ INV_ALT;
   assign p_eff = p_a & PRI_ON;
   assign a_eff = a_a & ALT_ON;
   assign quiet = !p_eff && !a_eff;

   always @(negedge clk) begin
      if (g_a) begin
         assert_init_value_R1: assert (q == {WIDTH{INIT_ONE}})
            else $error("init value not held");
      end
   end

   generate
      if (KIND == SRK_SYNC) begin : g_sync_props
         if (PRI_ON) begin : g_p
            assert_pri_force_R2: assert property (@(posedge clk) disable iff (g_a)
               (p_eff && !a_eff) |=> (q == PRI_VEC));
         end
         if (ALT_ON) begin : g_a2
            assert_alt_force_R3: assert property (@(posedge clk) disable iff (g_a)
               (a_eff && !p_eff) |=> (q == ALT_VEC));
         end
         if (PRI_ON && ALT_ON) begin : g_both
            assert_reset_wins_R4: assert property (@(posedge clk) disable iff (g_a)
               (p_eff && a_eff) |=> (q == '0));
         end
      end
      if (KIND == SRK_ASYNC) begin : g_async_props
         if (PRI_ON && !PRI_HIGH) begin : g_p
            assert_async_pri_R6: assert property (@(posedge clk) disable iff (g_a)
               p_eff |-> (q == '0));
         end
         if (ALT_ON && PRI_HIGH) begin : g_a2
            assert_async_alt_R6: assert property (@(posedge clk) disable iff (g_a)
               a_eff |-> (q == '0));
         end
      end
      if (KIND != SRK_ASYNC) begin : g_data_props
         if (CE_USED) begin : g_hold
            assert_ce_hold_R8: assert property (@(posedge clk) disable iff (g_a)
               (quiet && !ce_a) |=> $stable(q));
         end
         assert_load_d_R9: assert property (@(posedge clk) disable iff (g_a)
            (quiet && ce_a) |=> (q == $past(d)));
      end
   endgenerate
endmodule

bind cfg_srff cfg_srff_chk #(
   .WIDTH(WIDTH), .KIND(KIND), .HAS_SET(HAS_SET), .HAS_RST(HAS_RST),
   .PRI_HIGH(PRI_HIGH), .INIT_ONE(INIT_ONE), .CE_USED(CE_USED),
   .INV_CE(INV_CE), .INV_PRI(INV_PRI), .INV_ALT(INV_ALT), .INV_INIT(INV_INIT)
) u_chk (
   .clk(clk), .ginit(ginit), .ce(ce), .force_pri(force_pri),
   .force_alt(force_alt), .d(d), .q(q)
);

// File: tb/cfg_srff_tb_top.sv
module cfg_srff_tb_top;
   import srff_pkg::*;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic ginit = 1'b0;
   logic ginit_n;
   assign ginit_n = ~ginit;

   // A: sync, pri forces ones, init zero
   logic ce_a = 1'b1, p_a = 1'b0, r_a = 1'b0;
   logic [3:0] d_a = 4'h0, q_a;
   // B: async, pri forces zeros (active low), init one, ce and init active low
   logic ce_b = 1'b0, p_b = 1'b1, r_b = 1'b0;
   logic [3:0] d_b = 4'h0, q_b;
   // C: sync, only the set function, ce unused, init one
   logic ce_c = 1'b0, p_c = 1'b0, r_c = 1'b0;
   logic [3:0] d_c = 4'h0, q_c;

   cfg_srff #(.WIDTH(4), .KIND(SRK_SYNC), .PRI_HIGH(1'b1), .INIT_ONE(1'b0)) dut_i (
      .clk(clk), .ginit(ginit), .ce(ce_a), .force_pri(p_a), .force_alt(r_a), .d(d_a), .q(q_a));

   cfg_srff #(.WIDTH(4), .KIND(SRK_ASYNC), .PRI_HIGH(1'b0), .INIT_ONE(1'b1),
              .INV_CE(1'b1), .INV_PRI(1'b1), .INV_INIT(1'b1)) dut_b (
      .clk(clk), .ginit(ginit_n), .ce(ce_b), .force_pri(p_b), .force_alt(r_b), .d(d_b), .q(q_b));

   cfg_srff #(.WIDTH(4), .KIND(SRK_SYNC), .HAS_RST(1'b0), .PRI_HIGH(1'b0), .INIT_ONE(1'b1),
              .CE_USED(1'b0)) dut_c (
      .clk(clk), .ginit(ginit), .ce(ce_c), .force_pri(p_c), .force_alt(r_c), .d(d_c), .q(q_c));

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      #1 ginit = 1'b1;
      step();
      chk("R1 init A zero despite ones target", q_a, 4'h0);
      chk("R1 R7 init B ones via active-low init", q_b, 4'hF);
      chk("R1 init C ones", q_c, 4'hF);
      ginit = 1'b0;
      step();
   endtask

   task automatic t_capture();
      ce_a = 1'b1; d_a = 4'h5;
      ce_b = 1'b0; d_b = 4'h3;
      step();
      chk("R8 A loads with ce", q_a, 4'h5);
      chk("R7 R8 B loads with low ce", q_b, 4'h3);
      ce_a = 1'b0; d_a = 4'hA;
      ce_b = 1'b1; d_b = 4'hC;
      step();
      chk("R8 A holds without ce", q_a, 4'h5);
      chk("R7 R8 B holds with high ce", q_b, 4'h3);
   endtask

   task automatic t_ce_tied();
      ce_c = 1'b0; d_c = 4'h9;
      step();
      chk("R9 C loads with ce low", q_c, 4'h9);
      ce_c = 1'b1; d_c = 4'h6;
      step();
      chk("R9 C loads with ce high", q_c, 4'h6);
      ce_c = 1'b0; d_c = 4'hA;
      step();
      chk("R9 C loads again", q_c, 4'hA);
   endtask

   task automatic t_sync_force();
      ce_a = 1'b0; p_a = 1'b1;
      #1 chk("R5 no change before edge", q_a, 4'h5);
      step();
      chk("R2 R5 pri forces ones with ce low", q_a, 4'hF);
      p_a = 1'b0; r_a = 1'b1;
      step();
      chk("R3 alt forces zeros", q_a, 4'h0);
      p_a = 1'b1; r_a = 1'b0;
      step();
      chk("R2 pri again", q_a, 4'hF);
      r_a = 1'b1;
      step();
      chk("R4 both gives zeros", q_a, 4'h0);
      p_a = 1'b0; r_a = 1'b0; ce_a = 1'b1; d_a = 4'h6;
      step();
      chk("R8 A loads after release", q_a, 4'h6);
   endtask

   task automatic t_async_force();
      ce_b = 1'b0; d_b = 4'h5;
      step();
      chk("R8 B preload", q_b, 4'h5);
      #2 p_b = 1'b0;
      #1 chk("R2 R6 R7 pri low clears at once", q_b, 4'h0);
      step();
      chk("R6 held across edge", q_b, 4'h0);
      p_b = 1'b1;
      step();
      chk("R8 B reloads", q_b, 4'h5);
      #2 r_b = 1'b1;
      #1 chk("R3 R6 alt sets at once", q_b, 4'hF);
      #1 p_b = 1'b0;
      #1 chk("R4 R6 clear wins over held set", q_b, 4'h0);
      p_b = 1'b1; r_b = 1'b0;
      step();
      chk("R8 B reloads after release", q_b, 4'h5);
   endtask

   task automatic t_disabled();
      d_c = 4'h6; p_c = 1'b1;
      step();
      chk("R10 disabled reset ignored", q_c, 4'h6);
      r_c = 1'b1;
      step();
      chk("R3 alt sets C", q_c, 4'hF);
      d_c = 4'h3;
      step();
      chk("R10 disabled reset does not win", q_c, 4'hF);
      p_c = 1'b0; r_c = 1'b0;
      step();
      chk("R9 C loads after release", q_c, 4'h3);
   endtask

   task automatic t_init_async();
      ce_a = 1'b1; d_a = 4'h7;
      step();
      chk("R8 A preload", q_a, 4'h7);
      #3 ginit = 1'b1;
      #1 chk("R1 A init at once", q_a, 4'h0);
      chk("R1 B init at once", q_b, 4'hF);
      chk("R1 C init at once", q_c, 4'hF);
      p_a = 1'b1;
      step();
      chk("R1 init overrides force", q_a, 4'h0);
      p_a = 1'b0;
      ginit = 1'b0;
      step();
      chk("R1 A runs after init", q_a, 4'h7);
      chk("R1 B runs after init", q_b, 4'h5);
   endtask

   initial begin
      t_reset();
      t_capture();
      t_ce_tied();
      t_sync_force();
      t_async_force();
      t_disabled();
      t_init_async();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule